// File: doc/BRIEF.md
# Configurable PWM Channel

A single pulse-width-modulation channel with four 32-bit registers: a read-only tick counter, a period value, a duty value and a control word. A host reaches them over a small request/response port. The block drives one output pin. A two-stage divider sets the rate at which the counter advances. The counter runs either as a sawtooth (left aligned) or as a triangle (center aligned). The output shows the active level while the counter is below the duty value. A channel runs forever in continuous mode, or for a burst of whole periods in one-shot mode, after which it disables itself.

The request port accepts one access per cycle. `req_ready` is always high, so the block never applies back-pressure. A read request accepted on a clock edge returns its data with `rsp_valid` high for exactly the following cycle. The response has no ready signal, so the host must take it in that cycle. Writes produce no response. Byte offsets select the registers: 0x0 counter, 0x4 period, 0x8 duty, 0xC control.

Top module: `pwmc_top`

## Requirements
- R1: After reset the output is low, and the counter, period, duty and control registers all read 0.
- R2: Period (0x4) and duty (0x8) read back what was written. Control (0xC) reads back the written value with bits 6, 7, 10, 11 and 15 forced to 0. Writes to the counter (0x0) are ignored, and the counter reads 0 while the channel is stopped.
- R3: Control fields are: bit 0 enable; bits [2:1] mode (00 one-shot, 01 continuous, 10 and 11 capture); bit 3 active level; bit 4 idle level; bit 5 center alignment; bit 8 low-power; bit 9 scaled clock; bits [14:12] prescale exponent; bits [23:16] scale; bits [31:24] repeat count.
- R4: Left-aligned counting with period P ≥ 1: the counter takes the values 0, 1, …, P-1 and wraps, advancing once per divider tick. With enable written on edge E, the counter is 0 after E and first advances on edge E+N.
- R5: Center-aligned counting (bit 5 = 1) with P ≥ 1: the counter goes 0 up to P and back down to 1, then returns to 0. A full period is 2P ticks.
- R6: While running, the output equals the active level when the counter is below the duty value D, and its complement otherwise. While not running, the output equals the idle level.
- R7: With P ≥ 1, D = 0 never shows the active level. D ≥ P shows the active level for the whole run.
- R8: The divider ratio is N = 2^pre when bit 9 is clear. When bit 9 is set, N = 2^pre × 2 × scale, where a scale of 0 counts as 256 (N = 2^pre × 512).
- R9: With low-power set and the channel disabled, the divider is held at its start, so the counter phase after an enable is exactly as given in R4.
- R10: Period and duty written while the channel runs take effect at the next return of the counter to 0. While the channel is stopped they take effect at once.
- R11: One-shot mode (00) runs repeat+1 full periods. On the edge that ends the last period, the enable bit reads back 0 and the output turns to the idle level.
- R12: In capture modes (10, 11) the counter stays at 0 and the output holds the idle level even with enable set.
- R13: `req_ready` is always 1. A read is answered with `rsp_valid` high in the cycle after it is accepted, and `rsp_valid` is low after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data |
| pwm_out | output | 1 | PWM output pin |

## Verification
A divider that is off by one tick, or a prescaler left running through a low-power stop, moves every output edge. The first wrong level then appears N cycles after enable. A counter that wraps at the wrong value, or turns at the wrong point in center mode, shows as a wrong high or low time within the first period. A shadow loaded too early changes the output inside the period in which period or duty was rewritten, rather than after it. A repeat counter that is off by one leaves the pin active one period too long or too short, and the enable bit then reads back wrong right after the burst.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int REG_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int PRE_W    = 3;
  localparam int SCALE_W  = 8;
  localparam int RPT_W    = 8;

  // register select = byte offset bits [3:2]
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_PER  = 2'd1;
  localparam logic [1:0] SEL_DUTY = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // writable control bits; the reserved ones read back 0
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'hFFFF_733F;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'b00,
    MODE_CONT    = 2'b01,
    MODE_CAPT    = 2'b10,
    MODE_CAPT2   = 2'b11
  } mode_e;

  typedef struct packed {
    logic [RPT_W-1:0]   rpt;      // 31:24
    logic [SCALE_W-1:0] scale;    // 23:16
    logic               rsv_c;    // 15
    logic [PRE_W-1:0]   pre;      // 14:12
    logic [1:0]         rsv_b;    // 11:10
    logic               scaled;   // 9
    logic               lowpow;   // 8
    logic [1:0]         rsv_a;    // 7:6
    logic               center;   // 5
    logic               idle_lvl; // 4
    logic               act_lvl;  // 3
    mode_e              mode;     // 2:1
    logic               en;       // 0
  } ctrl_t;

endpackage

// File: rtl/pwmc_clkdiv.sv
module pwmc_clkdiv #(
  parameter int PRE_W   = 3,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [PRE_W-1:0]   pre_exp,
  input  logic               use_scale,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int PCNT_W = (1 << PRE_W) - 1;
  localparam int SCNT_W = SCALE_W + 1;

  logic [PCNT_W-1:0] pcnt, pmask;
  logic [SCNT_W-1:0] scnt, slim_m1;
  logic              pre_tick, scale_wrap;

  always_comb begin
    pmask      = PCNT_W'((32'd1 << pre_exp) - 32'd1);
    pre_tick   = (pcnt >= pmask);
    slim_m1    = (scale == '0) ? {SCNT_W{1'b1}} : ({scale, 1'b0} - SCNT_W'(1));
    scale_wrap = (scnt >= slim_m1);
    tick       = pre_tick && (!use_scale || scale_wrap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      pcnt <= '0;
      scnt <= '0;
    end else begin
      pcnt <= pre_tick ? '0 : pcnt + PCNT_W'(1);
      if (!use_scale)
        scnt <= '0;
      else if (pre_tick)
        scnt <= scale_wrap ? '0 : scnt + SCNT_W'(1);
    end
  end

  // R9: a held divider restarts from its first step
  assert_hold_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pcnt == '0 && scnt == '0));

endmodule

// File: rtl/pwmc_core.sv
module pwmc_core #(
  parameter int CNT_W = 32,
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             center,
  input  logic             oneshot,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [RPT_W-1:0] rpt,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] per_act, duty_act, nxt_cnt;
  logic [RPT_W-1:0] nper;
  logic             down, nxt_down, bnd;

  always_comb begin
    nxt_cnt  = cnt + CNT_W'(1);
    nxt_down = down;
    bnd      = 1'b0;
    if (per_act == '0) begin
      nxt_cnt  = '0;
      nxt_down = 1'b0;
      bnd      = 1'b1;
    end else if (!center) begin
      nxt_down = 1'b0;
      if (cnt >= per_act - CNT_W'(1)) begin
        nxt_cnt = '0;
        bnd     = 1'b1;
      end
    end else if (!down) begin
      if (cnt >= per_act - CNT_W'(1)) begin
        nxt_cnt  = per_act;
        nxt_down = 1'b1;
      end
    end else begin
      if (cnt <= CNT_W'(1)) begin
        nxt_cnt  = '0;
        nxt_down = 1'b0;
        bnd      = 1'b1;
      end else begin
        nxt_cnt = cnt - CNT_W'(1);
      end
    end
  end

  assign done   = run && tick && bnd && oneshot && (nper == rpt);
  assign active = (duty_act >= per_act) || (cnt < duty_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      down     <= 1'b0;
      nper     <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (!run) begin
      cnt      <= '0;
      down     <= 1'b0;
      nper     <= '0;
      per_act  <= per_in;
      duty_act <= duty_in;
    end else if (tick) begin
      cnt  <= nxt_cnt;
      down <= nxt_down;
      if (bnd) begin
        per_act  <= per_in;
        duty_act <= duty_in;
        nper     <= nper + RPT_W'(1);
      end
    end
  end

  // R4/R5: the count never passes the period in force
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  // R12: a stopped or capture-mode channel parks its counter at 0
  assert_idle_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R11: the last one-shot period ends with the counter at 0
  assert_done_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == '0));

  // R10: the period in force changes only on a wrap or while stopped
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && bnd)) |=> $stable(per_act));

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              pwm_out
);
  logic [REG_W-1:0] per_q, duty_q, cnt;
  ctrl_t            ctrl_q;
  logic [1:0]       sel;
  logic             wr_en, rd_en, wr_ctrl;
  logic             run, hold, tick, active, os_done;

  assign req_ready = 1'b1;
  assign sel       = req_addr[3:2];
  assign wr_en     = req_valid && req_write;
  assign rd_en     = req_valid && !req_write;
  assign wr_ctrl   = wr_en && (sel == SEL_CTRL);

  assign run  = ctrl_q.en && (ctrl_q.mode == MODE_ONESHOT || ctrl_q.mode == MODE_CONT);
  assign hold = ctrl_q.lowpow && !ctrl_q.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && sel == SEL_PER)  per_q  <= req_wdata;
      if (wr_en && sel == SEL_DUTY) duty_q <= req_wdata;
      if (wr_ctrl)
        ctrl_q <= ctrl_t'(req_wdata & CTRL_WMASK);
      else if (os_done)
        ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        unique case (sel)
          SEL_CNT:  rsp_rdata <= cnt;
          SEL_PER:  rsp_rdata <= per_q;
          SEL_DUTY: rsp_rdata <= duty_q;
          default:  rsp_rdata <= ctrl_q;
        endcase
      end
    end
  end

  pwmc_clkdiv #(.PRE_W(PRE_W), .SCALE_W(SCALE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .pre_exp  (ctrl_q.pre),
    .use_scale(ctrl_q.scaled),
    .scale    (ctrl_q.scale),
    .tick     (tick)
  );

  pwmc_core #(.CNT_W(REG_W), .RPT_W(RPT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .center (ctrl_q.center),
    .oneshot(ctrl_q.mode == MODE_ONESHOT),
    .tick   (tick),
    .per_in (per_q),
    .duty_in(duty_q),
    .rpt    (ctrl_q.rpt),
    .cnt    (cnt),
    .active (active),
    .done   (os_done)
  );

  assign pwm_out = run ? (active ? ctrl_q.act_lvl : !ctrl_q.act_lvl) : ctrl_q.idle_lvl;

  // R11: a finished burst clears enable unless the host rewrites control
  assert_oneshot_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (os_done && !wr_ctrl) |=> !ctrl_q.en);

  // R13: each read is answered in the next cycle
  assert_read_answer_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  // R13: no response without a read
  assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);

endmodule

// File: tb/pwmc_top_test.sv
module pwmc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        pwm_out;

  int total = 0;
  int bad = 0;
  logic last_rv;

  localparam logic [3:0] A_CNT = 4'h0, A_PER = 4'h4, A_DUTY = 4'h8, A_CTRL = 4'hC;
  localparam logic [31:0] EN = 32'h1, CONT = 32'h2, ACT = 32'h8, IDLE = 32'h10,
                          CTR = 32'h20, LP = 32'h100, SCL = 32'h200;

  always #10 clk = ~clk;

  pwmc_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; capture on the next posedge; returns at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    last_rv = rsp_valid;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    last_rv = rsp_valid;
  endtask

  function automatic logic exp_out(int j, int p, int d, bit ctr, int n, bit ap);
    int t, c, m;
    t = j / n;
    if (ctr) begin
      m = t % (2 * p);
      c = (m <= p) ? m : 2 * p - m;
    end else begin
      c = t % p;
    end
    return ((d >= p) || (c < d)) ? ap : !ap;
  endfunction

  // returns at j = 0 (first negedge after the enabling edge)
  task automatic configure(input int p, input int d, input logic [31:0] w);
    wr(A_CTRL, w & ~EN);
    wr(A_PER, p);
    wr(A_DUTY, d);
    wr(A_CTRL, w);
  endtask

  task automatic run_check(input string tag, input int p, input int d, input bit ctr,
                           input int n, input bit ap, input int len);
    for (int j = 0; j < len; j++) begin
      check(tag, pwm_out, exp_out(j, p, d, ctr, n, ap));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 out", pwm_out, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
    rd(A_PER, v);  check("R1 per", v, 0);
    rd(A_DUTY, v); check("R1 duty", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);

    // R13: ready, read answer, no answer after write
    check("R13 ready", req_ready, 1);
    rd(A_PER, v); check("R13 rsp_valid read", last_rv, 1);
    wr(A_PER, 0); check("R13 rsp_valid write", last_rv, 0);

    // R2: readback and masking, counter write ignored
    wr(A_PER, 32'h1234_5678);  rd(A_PER, v);  check("R2 per", v, 32'h1234_5678);
    wr(A_DUTY, 32'h0BAD_F00D); rd(A_DUTY, v); check("R2 duty", v, 32'h0BAD_F00D);
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); check("R2 R3 ctrl mask", v, 32'hFFFF_733E);
    wr(A_CTRL, 0);
    wr(A_CNT, 32'h5);          rd(A_CNT, v);  check("R2 cnt write ignored", v, 0);

    // R4 R6 R7: left-aligned sweep
    for (int p = 1; p <= 5; p++)
      for (int d = 0; d <= p + 1; d++) begin
        configure(p, d, EN | CONT | ACT);
        run_check("R4 R7 left sweep", p, d, 0, 1, 1, 4 * p + 3);
      end

    // R5 R7: center-aligned sweep
    for (int p = 1; p <= 4; p++)
      for (int d = 0; d <= p + 1; d++) begin
        configure(p, d, EN | CONT | ACT | CTR);
        run_check("R5 R7 center sweep", p, d, 1, 1, 1, 4 * p + 3);
      end

    // R6: inverted active level, then idle level after disable
    configure(4, 1, EN | CONT | IDLE);
    run_check("R6 active low", 4, 1, 0, 1, 0, 12);
    wr(A_CTRL, IDLE);
    check("R6 idle high", pwm_out, 1);

    // R8 R9: prescale 4, low-power hold
    configure(2, 1, EN | CONT | ACT | LP | (32'd2 << 12));
    run_check("R8 R9 prescale 4", 2, 1, 0, 4, 1, 24);

    // R8: prescale 2, scale 3 -> N = 12
    configure(2, 1, EN | CONT | ACT | LP | SCL | (32'd1 << 12) | (32'd3 << 16));
    run_check("R8 scale 3", 2, 1, 0, 12, 1, 60);

    // R8: scale 0 counts as 256 -> N = 2*512
    configure(2, 1, EN | CONT | ACT | LP | SCL | (32'd1 << 12));
    run_check("R8 scale 0", 2, 1, 0, 1024, 1, 2100);

    // R10: period change while running waits for the wrap at edge E+8
    configure(4, 2, EN | CONT | ACT);
    run_check("R10 before write", 4, 2, 0, 1, 1, 4);
    wr(A_PER, 6);
    for (int j = 5; j < 8; j++) begin
      check("R10 old period kept", pwm_out, exp_out(j, 4, 2, 0, 1, 1));
      @(negedge clk);
    end
    run_check("R10 new period", 6, 2, 0, 1, 1, 14);

    // R11: one-shot, repeat 2 -> 3 periods of 3
    configure(3, 1, EN | ACT | IDLE | (32'd2 << 24));
    for (int j = 0; j < 14; j++) begin
      check("R11 burst", pwm_out, (j < 9) ? exp_out(j, 3, 1, 0, 1, 1) : 1'b1);
      @(negedge clk);
    end
    rd(A_CTRL, v); check("R11 enable cleared", v, ACT | IDLE | (32'd2 << 24));

    // R12: capture modes hold idle level and zero counter
    configure(3, 1, EN | 32'h4 | IDLE);
    for (int j = 0; j < 8; j++) begin
      check("R12 capture out", pwm_out, 1);
      @(negedge clk);
    end
    rd(A_CNT, v); check("R12 capture cnt", v, 0);
    configure(3, 1, EN | 32'h6);
    run_check("R12 mode 11 idle low", 3, 0, 0, 1, 1, 1);
    rd(A_CNT, v); check("R12 mode 11 cnt", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule